// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes an asynchronous serial line and turns it into characters. A clock generator outside the block supplies a sample tick at sixteen times the bit rate. The receiver synchronises the line and finds the start of each frame. It decides every bit by a majority of three samples taken around the bit centre. It then strips the start, parity and stop bits, checks parity and places the character in a two-entry receive buffer. A reader drains the buffer one character at a time with a read strobe.

The frame format is set by a data-width code, a parity mode and a double-speed flag. In double-speed mode each bit lasts eight ticks instead of sixteen. Every buffered character carries its own frame-error and parity-error flags. An overrun flag is shown alongside the next character the reader takes. The flags appear on the outputs together with the character's data. Either stop-bit count is accepted, because only the first stop bit is examined.

The frame controller has five states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY` and `ST_STOP`. The transitions are:
- `ST_IDLE` to `ST_START` on a falling edge seen at a tick.
- `ST_START` back to `ST_IDLE` when the start vote is high, which rejects the start.
- `ST_START` to `ST_DATA` at the end of an accepted start bit.
- `ST_DATA` to `ST_PARITY` at the end of the last data bit when parity is enabled, or to `ST_STOP` when it is not.
- `ST_PARITY` to `ST_STOP` at the end of the parity bit.
- `ST_STOP` to `ST_IDLE` once the first stop bit has been voted, which also stores the character.

Top module: `serial_rx_recover`

## Requirements
- R1: The width code `width_i` selects the number of data bits: 0→5, 1→6, 2→7, 3→8, 4→9, and codes 5 to 7 mean 8. Bits arrive least significant first. The character is presented right-justified in `rx_data_o`, with zeros above its width.
- R2: A frame starts on a tick that sees the line low after a tick that saw it high. If the majority vote in the middle of the start bit is high, the receiver returns to idle and stores nothing.
- R3: In normal mode each bit is the majority of samples 8, 9 and 10 of its 16 ticks. A single wrong sample among them does not change the bit.
- R4: `parity_i` selects the parity mode: 2'b10 even, 2'b11 odd, 2'b00 and 2'b01 none. With parity on, the parity error is set when the received parity bit differs from the one computed over the data. With parity off, no parity bit is expected and the parity error is always 0.
- R5: The frame error is set when the first stop bit votes low. That character is still stored. No later stop bit is checked.
- R6: The buffer holds two characters, read oldest first. `avail_o` is high while at least one is held, and a pulse on `rd_i` removes the oldest. A read strobe with the buffer empty has no effect.
- R7: A character that completes while both entries are full is discarded. `overrun_o` is then high together with the next character presented, and clears once that character is read.
- R8: Frame-error and parity-error flags are stored with each character and shown with it. All three flags and the data are 0 while `avail_o` is low.
- R9: After reset, `avail_o`, `rx_data_o` and all flags are 0.
- R10: With `dbl_i` high each bit lasts 8 ticks and is the majority of samples 4, 5 and 6, with the same single-sample tolerance as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversample tick, one clock wide |
| dbl_i | input | 1 | Double-speed mode (8 ticks per bit) |
| width_i | input | 3 | Data-width code |
| parity_i | input | 2 | Parity mode |
| rd_i | input | 1 | Read strobe, removes the oldest character |
| rx_data_o | output | 9 | Oldest buffered character |
| avail_o | output | 1 | Buffer holds at least one character |
| frame_err_o | output | 1 | Frame error of the presented character |
| parity_err_o | output | 1 | Parity error of the presented character |
| overrun_o | output | 1 | A character was lost before this one was read |

## Verification
The bench sends a low pulse too short to reach the start-bit centre. A receiver that skipped the start vote would store a spurious character. It forces one sample inside the voting window to the wrong value, in both speed modes. A receiver that took a single sample, or voted at the wrong tick positions, would return a corrupted character. Three characters are sent without reading. This checks that the third is dropped and that the overrun flag goes with the next character read and not the one after it. Frames with a low stop bit and with a flipped parity bit, at 5, 6, 7, 8 and 9 data bits, check that each flag goes with its own character and that the data is right-justified.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ferr;
        logic                perr;
    } rx_char_t;

    function automatic logic [3:0] width_bits(input logic [2:0] code);
        logic [3:0] n;
        unique case (code)
            3'd0:    n = 4'd5;
            3'd1:    n = 4'd6;
            3'd2:    n = 4'd7;
            3'd4:    n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rxr_sampler.sv
module rxr_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    input  logic tick_i,
    input  logic dbl_i,
    input  logic busy_i,
    output logic start_o,
    output logic bit_done_o,
    output logic bit_val_o,
    output logic bit_end_o
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST_N = CW'(OSR - 1);
    localparam logic [CW-1:0] LAST_D = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] MID_N  = CW'(OSR / 2);
    localparam logic [CW-1:0] MID_D  = CW'(OSR / 4);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    votes_q;
    logic          rx_s;
    logic [CW-1:0] mid;
    logic [CW-1:0] last;
    logic          in_window;

    assign rx_s      = sync_q[1];
    assign mid       = dbl_i ? MID_D : MID_N;
    assign last      = dbl_i ? LAST_D : LAST_N;
    assign in_window = (cnt_q == mid - 1'b1) || (cnt_q == mid) || (cnt_q == mid + 1'b1);

    assign start_o    = tick_i && !busy_i && prev_q && !rx_s;
    assign bit_done_o = tick_i && busy_i && (cnt_q == mid + 1'b1);
    assign bit_val_o  = (votes_q[1] & votes_q[0]) | (votes_q[1] & rx_s) | (votes_q[0] & rx_s);
    assign bit_end_o  = tick_i && busy_i && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            prev_q  <= 1'b1;
            cnt_q   <= '0;
            votes_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rx_i};
            if (tick_i) begin
                prev_q <= rx_s;
            end
            if (start_o) begin
                cnt_q <= CW'(1);
            end else if (tick_i && busy_i) begin
                cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
            end
            if (tick_i && busy_i && in_window) begin
                votes_q <= {votes_q[0], rx_s};
            end
        end
    end

endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       bit_done_i,
    input  logic       bit_val_i,
    input  logic       bit_end_i,
    input  logic [2:0] width_i,
    input  logic [1:0] parity_i,
    output logic       busy_o,
    output logic       push_o,
    output rx_char_t   push_char_o
);
    rx_state_e           state_q, state_d;
    logic [MAX_BITS-1:0] shreg_q;
    logic [3:0]          nbits_q;
    logic                par_bit_q;
    logic [3:0]          nbits;
    logic                par_en;
    logic [MAX_BITS-1:0] aligned;
    logic                par_expect;

    assign nbits      = width_bits(width_i);
    assign par_en     = parity_i[1];
    assign aligned    = shreg_q >> (4'(MAX_BITS) - nbits);
    assign par_expect = parity_i[0] ? ~(^aligned) : (^aligned);
    assign busy_o     = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_START;
            end
            ST_START: begin
                if (bit_done_i && bit_val_i) state_d = ST_IDLE;
                else if (bit_end_i)          state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end_i && nbits_q == nbits)
                    state_d = par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end_i) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            nbits_q     <= '0;
            par_bit_q   <= 1'b0;
            push_o      <= 1'b0;
            push_char_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (state_q == ST_IDLE && start_i) begin
                nbits_q <= '0;
                shreg_q <= '0;
            end
            if (state_q == ST_DATA && bit_done_i) begin
                shreg_q <= {bit_val_i, shreg_q[MAX_BITS-1:1]};
                nbits_q <= nbits_q + 1'b1;
            end
            if (state_q == ST_PARITY && bit_done_i) begin
                par_bit_q <= bit_val_i;
            end
            if (state_q == ST_STOP && bit_done_i) begin
                push_o           <= 1'b1;
                push_char_o.data <= aligned;
                push_char_o.ferr <= !bit_val_i;
                push_char_o.perr <= par_en && (par_bit_q != par_expect);
            end
        end
    end

    a_r5_store_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> (state_q == ST_IDLE && $past(state_q) == ST_STOP));

    a_r4_no_perr_unless_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && !par_en) |-> !push_char_o.perr);

    a_r1_zero_above_width: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ((push_char_o.data >> nbits) == '0));

    a_r2_start_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && bit_done_i && bit_val_i) |=> (!push_o && !busy_o));

endmodule

// File: rtl/rxr_buffer.sv
module rxr_buffer
    import rxr_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  rx_char_t push_char_i,
    input  logic     pop_i,
    output rx_char_t head_o,
    output logic     avail_o,
    output logic     ovr_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL     = CW'(DEPTH);

    rx_char_t      mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] count_q;
    logic          ovr_q;
    logic          do_pop, do_push, drop;

    assign do_pop  = pop_i && (count_q != '0);
    assign do_push = push_i && ((count_q != FULL) || do_pop);
    assign drop    = push_i && !do_push;
    assign avail_o = (count_q != '0);
    assign head_o  = avail_o ? mem_q[rd_q] : '0;
    assign ovr_o   = avail_o && ovr_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (do_push && wr_q == PW'(g)) begin
                mem_q[g] <= push_char_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
            if (drop)        ovr_q <= 1'b1;
            else if (do_pop) ovr_q <= 1'b0;
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);

    a_r7_drop_marks_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && count_q == FULL && !pop_i) |=> (ovr_o && count_q == FULL));

endmodule

// File: rtl/serial_rx_recover.sv
module serial_rx_recover
    import rxr_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_i,
    input  logic                tick_i,
    input  logic                dbl_i,
    input  logic [2:0]          width_i,
    input  logic [1:0]          parity_i,
    input  logic                rd_i,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                avail_o,
    output logic                frame_err_o,
    output logic                parity_err_o,
    output logic                overrun_o
);
    logic     start, bit_done, bit_val, bit_end, busy, push;
    rx_char_t push_char, head;

    rxr_sampler #(.OSR(OSR)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .tick_i     (tick_i),
        .dbl_i      (dbl_i),
        .busy_i     (busy),
        .start_o    (start),
        .bit_done_o (bit_done),
        .bit_val_o  (bit_val),
        .bit_end_o  (bit_end)
    );

    rxr_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .bit_done_i  (bit_done),
        .bit_val_i   (bit_val),
        .bit_end_i   (bit_end),
        .width_i     (width_i),
        .parity_i    (parity_i),
        .busy_o      (busy),
        .push_o      (push),
        .push_char_o (push_char)
    );

    rxr_buffer #(.DEPTH(DEPTH)) u_buffer (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_char_i (push_char),
        .pop_i       (rd_i),
        .head_o      (head),
        .avail_o     (avail_o),
        .ovr_o       (overrun_o)
    );

    assign rx_data_o    = head.data;
    assign frame_err_o  = head.ferr;
    assign parity_err_o = head.perr;

    a_r8_flags_need_char: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_o |-> !(frame_err_o || parity_err_o || overrun_o || rx_data_o != '0));

endmodule

// File: tb/tb_serial_rx_recover.sv
module tb_serial_rx_recover;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       dbl = 1'b0;
    logic [2:0] width = 3'd3;
    logic [1:0] parity = 2'd0;
    logic       rd = 1'b0;
    logic [8:0] rx_data;
    logic       avail, ferr, perr, ovr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_rx_recover dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .dbl_i(dbl),
        .width_i(width), .parity_i(parity), .rd_i(rd),
        .rx_data_o(rx_data), .avail_o(avail), .frame_err_o(ferr),
        .parity_err_o(perr), .overrun_o(ovr)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // {dbl, width code, parity mode, flip parity, low stop, sent data, exp data, exp ferr, exp perr}
    localparam logic [27:0] VEC [8] = '{
        {1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
        {1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 9'h1F3, 9'h013, 1'b0, 1'b0},
        {1'b0, 3'd4, 2'd2, 1'b0, 1'b0, 9'h155, 9'h155, 1'b0, 1'b0},
        {1'b0, 3'd4, 2'd3, 1'b1, 1'b0, 9'h0F0, 9'h0F0, 1'b0, 1'b1},
        {1'b0, 3'd2, 2'd2, 1'b0, 1'b1, 9'h07F, 9'h07F, 1'b1, 1'b0},
        {1'b1, 3'd3, 2'd3, 1'b0, 1'b0, 9'h03C, 9'h03C, 1'b0, 1'b0},
        {1'b1, 3'd1, 2'd2, 1'b1, 1'b1, 9'h02A, 9'h02A, 1'b1, 1'b1},
        {1'b0, 3'd3, 2'd1, 1'b1, 1'b0, 9'h081, 9'h081, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic val, input bit glitch, input int bc, input int go);
        for (int c = 0; c < bc; c++) begin
            rx = (glitch && c >= go && c < go + 4) ? ~val : val;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic d2, input logic [2:0] wc, input logic [1:0] pm,
                              input logic flip, input logic stoplow, input logic [8:0] din,
                              input int gbit);
        int bc = d2 ? 32 : 64;
        int go = d2 ? 16 : 34;
        int nb = (wc <= 3'd4) ? int'(wc) + 5 : 8;
        logic [8:0] d = din & ((9'h1 << nb) - 9'h1);
        logic p = (pm[0] ? ~(^d) : (^d)) ^ flip;
        int idx = 0;
        dbl = d2; width = wc; parity = pm;
        send_bit(1'b0, gbit == idx, bc, go); idx++;
        for (int i = 0; i < nb; i++) begin
            send_bit(d[i], gbit == idx, bc, go); idx++;
        end
        if (pm[1]) begin
            send_bit(p, gbit == idx, bc, go); idx++;
        end
        send_bit(~stoplow, gbit == idx, bc, go);
        send_bit(1'b1, 1'b0, 2 * bc, go);
    endtask

    task automatic pop();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(avail == 1'b0, "R9", avail, 0);
        check(rx_data == 9'h0, "R9", rx_data, 0);
        check({ferr, perr, ovr} == 3'b000, "R9", {ferr, perr, ovr}, 0);

        // Table walk: R1 R4 R5 R8 R10
        for (int v = 0; v < 8; v++) begin
            send_frame(VEC[v][27], VEC[v][26:24], VEC[v][23:22], VEC[v][21], VEC[v][20],
                       VEC[v][19:11], -1);
            check(avail == 1'b1, "R6", avail, 1);
            check(rx_data == VEC[v][10:2], "R1", rx_data, VEC[v][10:2]);
            check(ferr == VEC[v][1], "R5", ferr, VEC[v][1]);
            check(perr == VEC[v][0], "R4", perr, VEC[v][0]);
            pop();
            check(avail == 1'b0, "R8", avail, 0);
        end

        // R2: short low pulse is rejected, then a real frame is received
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (200) @(negedge clk);
        check(avail == 1'b0, "R2", avail, 0);
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h03C, -1);
        check(rx_data == 9'h03C, "R2", rx_data, 9'h03C);
        pop();

        // R3: one wrong sample in the voting window of data bit 2
        send_frame(1'b0, 3'd3, 2'd2, 1'b0, 1'b0, 9'h055, 3);
        check(rx_data == 9'h055 && !perr, "R3", rx_data, 9'h055);
        pop();
        // R3: glitch on the start bit centre does not reject it
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h0C3, 0);
        check(avail && rx_data == 9'h0C3, "R3", rx_data, 9'h0C3);
        pop();
        // R10: double speed glitch tolerance
        send_frame(1'b1, 3'd3, 2'd3, 1'b0, 1'b0, 9'h0AA, 4);
        check(rx_data == 9'h0AA && !perr, "R10", rx_data, 9'h0AA);
        pop();

        // R6: read on empty has no effect; two entries read oldest first
        pop();
        check(avail == 1'b0, "R6", avail, 0);
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h011, -1);
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b1, 9'h022, -1);
        check(rx_data == 9'h011 && !ferr, "R6", rx_data, 9'h011);
        pop();
        check(avail && rx_data == 9'h022, "R6", rx_data, 9'h022);
        check(ferr == 1'b1, "R8", ferr, 1);
        pop();
        check(avail == 1'b0, "R6", avail, 0);

        // R7: third character while full is dropped
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h031, -1);
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h032, -1);
        check(ovr == 1'b0, "R7", ovr, 0);
        send_frame(1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 9'h033, -1);
        check(rx_data == 9'h031 && ovr, "R7", {ovr, rx_data}, {1'b1, 9'h031});
        pop();
        check(rx_data == 9'h032 && !ovr, "R7", {ovr, rx_data}, {1'b0, 9'h032});
        pop();
        check(avail == 1'b0 && !ovr, "R7", avail, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule